// File: doc/BRIEF.md
# Serial Multiply-Accumulate State Observer

This block estimates the internal state of a linearised suspension model, one discrete time step per request. It holds a 15-element state estimate and combines it with five sensor readings (three body accelerations, two body-to-chassis displacements) and a vector of actuator commands. From these it forms a new estimate and reports three derived quantities: the horizontal position, vertical position and roll angle of the body. One step computes the innovation `e = y - C*x`, then `x' = A*x + B*u + L*e`, then `z = D*x'`.

All matrix-vector products are broken into dot products, and every product term passes through a single multiply-accumulate unit, one term per clock. The cost is a fixed latency of several hundred cycles instead of an array of multipliers. Coefficients are signed Q2.14 values. They sit in an internal store loaded through an address/data/write-enable port while the engine is idle. A sequencer with the states IDLE, INNOV, UPDATE, COMMIT, OUTPUT and DONE steps through the work. IDLE goes to INNOV on start. INNOV goes to UPDATE after its last row, and UPDATE goes to COMMIT after its last row. COMMIT goes to OUTPUT after one cycle. OUTPUT goes to DONE after its last row, and DONE returns to IDLE after one cycle.

Top module: `susp_observer`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `est_o` is all zero, and the state estimate is zero.
- R2: A `start_i` high in IDLE begins a step. `busy_o` is high from the next cycle until the step ends. `done_o` is high for exactly one cycle, in the state entered LAT = NY*(NX+1) + NX*(NX+NU+NY+1) + 1 + NZ*(NX+1) clock edges after the accepting edge (534 with the defaults).
- R3: `start_i` while `busy_o` is high has no effect: the running step keeps its timing and produces exactly one `done_o`.
- R4: Coefficient writes while `busy_o` is high are discarded. Later steps still use the value held before the write.
- R5: Each innovation element is `e[i] = rs(y[i]*2^14 - sum_j C[i][j]*x[j])`, with `y` taken from `meas_i` lane i (bits `16*i +: 16`).
- R6: Each new state row is `x'[i] = rs(sum_j A[i][j]*x[j] + sum_j B[i][j]*u[j] + sum_j L[i][j]*e[j])`. Every row uses the old estimate, and the new estimate replaces the old one as a whole before the outputs are formed.
- R7: Each output is `z[i] = rs(sum_j D[i][j]*x'[j])` on `est_o` lane i. It changes only during a step and is valid when `done_o` is high.
- R8: `rs` rounds a sum in 2^-14 units by adding 2^13 and then shifting right arithmetically by 14 (so +1.5 gives 2 and -1.5 gives -1).
- R9: `rs` saturates to the range -32768 to 32767.
- R10: The coefficient address map is as follows. C[i][j] is at i*15+j. The state row i term j is at 75+i*26+j, where j 0..14 is A, j 15..20 is B and j 21..25 is L. D[i][j] is at 465+i*15+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start one observer step |
| meas_i | input | NY*DW | Measured sensor vector, lane i at bits DW*i |
| act_i | input | NU*DW | Actuator command vector |
| cfg_we_i | input | 1 | Coefficient write enable |
| cfg_addr_i | input | AW | Coefficient address |
| cfg_data_i | input | CW | Coefficient value, Q2.14 |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle pulse, outputs valid |
| est_o | output | NZ*DW | Estimated body position and roll |

## Verification
The first pattern uses a pure input-to-state matrix with half-unit output gains. It exposes the rounding direction on positive and negative ties without any state feedback. Dense pseudo-random coefficients over several chained steps mix every term kind, and off-diagonal state coupling reveals an estimate that is updated in place rather than through the shadow bank. Full-scale gains with large inputs separate correct saturation from wrap-around in both directions. A step disturbed by a stray start and a coefficient write shows whether either reaches the datapath.

// File: rtl/obs_pkg.sv
package obs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INNOV,
        PH_UPDATE,
        PH_COMMIT,
        PH_OUTPUT,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/obs_coef_ram.sv
module obs_coef_ram #(
    parameter int CW    = 16,
    parameter int DEPTH = 510,
    parameter int AW    = 9
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [CW-1:0] rdata
);
    logic signed [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH)))
            mem[waddr] <= wdata;
    end

    always_comb begin
        if (raddr < AW'(DEPTH))
            rdata = mem[raddr];
        else
            rdata = '0;
    end
endmodule

// File: rtl/obs_mac.sv
module obs_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int ACCW = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   first,
    input  logic                   negate,
    input  logic signed [ACCW-1:0] init,
    input  logic signed [CW-1:0]   coef,
    input  logic signed [DW-1:0]   opnd,
    output logic signed [DW-1:0]   res
);
    localparam int PW = CW + DW;
    localparam logic signed [ACCW-1:0] HALF = {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] prod_x, base, acc, rnd, shr;

    assign prod   = coef * opnd;
    assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};
    assign base   = first ? init : acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (en)
            acc <= negate ? (base - prod_x) : (base + prod_x);
    end

    always_comb begin
        rnd = acc + HALF;
        shr = rnd >>> FRAC;
        if (shr > MAXV)
            res = MAXV[DW-1:0];
        else if (shr < MINV)
            res = MINV[DW-1:0];
        else
            res = shr[DW-1:0];
    end
endmodule

// File: rtl/obs_seq.sv
module obs_seq
    import obs_pkg::*;
#(
    parameter int NX  = 15,
    parameter int NY  = 5,
    parameter int NZ  = 3,
    parameter int TU  = 26,
    parameter int RBW = 4,
    parameter int CBW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output phase_e         phase,
    output logic [RBW-1:0] row,
    output logic [CBW-1:0] col,
    output logic           mac_en,
    output logic           first,
    output logic           wb,
    output logic           busy,
    output logic           done
);
    phase_e st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_IDLE;
            row <= '0;
            col <= '0;
        end else begin
            unique case (st)
                PH_IDLE: begin
                    if (start) begin
                        st  <= PH_INNOV;
                        row <= '0;
                        col <= '0;
                    end
                end
                PH_INNOV: begin
                    if (col == CBW'(NX)) begin
                        col <= '0;
                        if (row == RBW'(NY-1)) begin
                            row <= '0;
                            st  <= PH_UPDATE;
                        end else
                            row <= row + 1'b1;
                    end else
                        col <= col + 1'b1;
                end
                PH_UPDATE: begin
                    if (col == CBW'(TU)) begin
                        col <= '0;
                        if (row == RBW'(NX-1)) begin
                            row <= '0;
                            st  <= PH_COMMIT;
                        end else
                            row <= row + 1'b1;
                    end else
                        col <= col + 1'b1;
                end
                PH_COMMIT: begin
                    st  <= PH_OUTPUT;
                    row <= '0;
                    col <= '0;
                end
                PH_OUTPUT: begin
                    if (col == CBW'(NX)) begin
                        col <= '0;
                        if (row == RBW'(NZ-1)) begin
                            row <= '0;
                            st  <= PH_DONE;
                        end else
                            row <= row + 1'b1;
                    end else
                        col <= col + 1'b1;
                end
                PH_DONE: st <= PH_IDLE;
                default: st <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        phase  = st;
        busy   = (st != PH_IDLE);
        done   = (st == PH_DONE);
        first  = (col == '0);
        mac_en = 1'b0;
        wb     = 1'b0;
        unique case (st)
            PH_INNOV, PH_OUTPUT: begin
                wb     = (col == CBW'(NX));
                mac_en = !wb;
            end
            PH_UPDATE: begin
                wb     = (col == CBW'(TU));
                mac_en = !wb;
            end
            default: begin
                wb     = 1'b0;
                mac_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/susp_observer.sv
module susp_observer
    import obs_pkg::*;
#(
    parameter int NX   = 15,
    parameter int NY   = 5,
    parameter int NU   = 6,
    parameter int NZ   = 3,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int ACCW = 40,
    localparam int TU    = NX + NU + NY,
    localparam int DEPTH = NY*NX + NX*TU + NZ*NX,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NY*DW-1:0]     meas_i,
    input  logic [NU*DW-1:0]     act_i,
    input  logic                 cfg_we_i,
    input  logic [AW-1:0]        cfg_addr_i,
    input  logic signed [CW-1:0] cfg_data_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [NZ*DW-1:0]     est_o
);
    localparam int OFF_U = NY*NX;
    localparam int OFF_O = OFF_U + NX*TU;
    localparam int RBW   = $clog2(NX + 1);
    localparam int CBW   = $clog2(TU + 1);

    phase_e               phase;
    logic [RBW-1:0]       row;
    logic [CBW-1:0]       col;
    logic                 mac_en, first, wb, ram_we;
    logic [AW-1:0]        raddr;
    logic signed [CW-1:0] coef;
    logic signed [DW-1:0] opnd, ysel, res;
    logic signed [ACCW-1:0] init;

    logic signed [DW-1:0] y_in [NY];
    logic signed [DW-1:0] u_in [NU];
    logic signed [DW-1:0] x_q  [NX];
    logic signed [DW-1:0] xn_q [NX];
    logic signed [DW-1:0] e_q  [NY];
    logic signed [DW-1:0] z_q  [NZ];

    genvar gi;
    generate
        for (gi = 0; gi < NY; gi++) begin : g_y
            assign y_in[gi] = meas_i[gi*DW +: DW];
        end
        for (gi = 0; gi < NU; gi++) begin : g_u
            assign u_in[gi] = act_i[gi*DW +: DW];
        end
        for (gi = 0; gi < NZ; gi++) begin : g_z
            assign est_o[gi*DW +: DW] = z_q[gi];
        end
    endgenerate

    obs_seq #(.NX(NX), .NY(NY), .NZ(NZ), .TU(TU), .RBW(RBW), .CBW(CBW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_i), .phase(phase), .row(row),
        .col(col), .mac_en(mac_en), .first(first), .wb(wb),
        .busy(busy_o), .done(done_o)
    );

    assign ram_we = cfg_we_i && !busy_o;

    obs_coef_ram #(.CW(CW), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(cfg_addr_i), .wdata(cfg_data_i),
        .raddr(raddr), .rdata(coef)
    );

    always_comb begin
        raddr = '0;
        opnd  = '0;
        ysel  = '0;
        unique case (phase)
            PH_INNOV: begin
                raddr = AW'(row) * AW'(NX) + AW'(col);
                if (int'(col) < NX) opnd = x_q[int'(col)];
                if (int'(row) < NY) ysel = y_in[int'(row)];
            end
            PH_UPDATE: begin
                raddr = AW'(OFF_U) + AW'(row) * AW'(TU) + AW'(col);
                if (int'(col) < NX)
                    opnd = x_q[int'(col)];
                else if (int'(col) < NX + NU)
                    opnd = u_in[int'(col) - NX];
                else if (int'(col) < TU)
                    opnd = e_q[int'(col) - NX - NU];
            end
            PH_OUTPUT: begin
                raddr = AW'(OFF_O) + AW'(row) * AW'(NX) + AW'(col);
                if (int'(col) < NX) opnd = x_q[int'(col)];
            end
            default: begin
                raddr = '0;
                opnd  = '0;
            end
        endcase
        if (phase == PH_INNOV)
            init = {{(ACCW-DW-FRAC){ysel[DW-1]}}, ysel, {FRAC{1'b0}}};
        else
            init = '0;
    end

    obs_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .ACCW(ACCW)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(mac_en), .first(first),
        .negate(phase == PH_INNOV), .init(init), .coef(coef), .opnd(opnd),
        .res(res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NX; i++) begin
                x_q[i]  <= '0;
                xn_q[i] <= '0;
            end
            for (int i = 0; i < NY; i++) e_q[i] <= '0;
            for (int i = 0; i < NZ; i++) z_q[i] <= '0;
        end else begin
            unique case (phase)
                PH_INNOV:  if (wb && int'(row) < NY) e_q[int'(row)] <= res;
                PH_UPDATE: if (wb) xn_q[int'(row)] <= res;
                PH_COMMIT: x_q <= xn_q;
                PH_OUTPUT: if (wb && int'(row) < NZ) z_q[int'(row)] <= res;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/obs_checker.sv
module obs_checker #(
    parameter int NX = 15,
    parameter int NY = 5,
    parameter int NU = 6,
    parameter int NZ = 3,
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             ram_we,
    input logic [NZ*DW-1:0] est
);
    localparam int LAT = NY*(NX+1) + NX*(NX+NU+NY+1) + 1 + NZ*(NX+1);

    logic [15:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start && !busy)
            cnt <= '0;
        else if (busy)
            cnt <= cnt + 1'b1;
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == 16'(LAT)));
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_cfg_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !busy);
    assert_est_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(est));
endmodule

bind susp_observer obs_checker #(.NX(NX), .NY(NY), .NU(NU), .NZ(NZ), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .done(done_o),
    .ram_we(ram_we), .est(est_o)
);

// File: tb/susp_observer_test.sv
module susp_observer_test;
    localparam int NX = 15, NY = 5, NU = 6, NZ = 3, DW = 16, CW = 16;
    localparam int TU = NX + NU + NY;
    localparam int DEPTH = NY*NX + NX*TU + NZ*NX;
    localparam int AW = $clog2(DEPTH);
    localparam int OFF_U = NY*NX;
    localparam int OFF_O = OFF_U + NX*TU;
    localparam int LAT = NY*(NX+1) + NX*(NX+NU+NY+1) + 1 + NZ*(NX+1);

    logic clk = 0, rst_n = 0, start = 0, cfg_we = 0;
    logic [NY*DW-1:0] meas = '0;
    logic [NU*DW-1:0] act = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic signed [CW-1:0] cfg_data = '0;
    logic busy, done;
    logic [NZ*DW-1:0] est;

    susp_observer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .meas_i(meas), .act_i(act),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .busy_o(busy), .done_o(done), .est_o(est)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    z [NZ];
        int    t0;
        string tag;
    } exp_t;
    exp_t q[$];

    int cf [DEPTH];
    int mx [NX];
    int seed = 7;

    function automatic int rs(longint a);
        longint r;
        r = (a + 64'sd8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R3 actual=extra done expected=no done");
            end else begin
                exp_t it;
                it = q.pop_front();
                check("R2 latency", cyc - it.t0, LAT + 1);
                for (int i = 0; i < NZ; i++)
                    check(it.tag, int'($signed(est[i*DW +: DW])), it.z[i]);
            end
        end
    end

    task automatic wr(int a, int v);
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(a); cfg_data = CW'(v);
        @(negedge clk);
        cfg_we = 0;
        if (!busy) cf[a] = v;
    endtask

    function automatic int rnd_coef(int span);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32767) % (2*span + 1) - span;
    endfunction

    task automatic run_step(int y[NY], int u[NU], string tag, bit disturb);
        exp_t it;
        int e[NY];
        int nx[NX];
        longint a;
        for (int i = 0; i < NY; i++) begin
            a = longint'(y[i]) <<< 14;
            for (int j = 0; j < NX; j++) a -= longint'(cf[i*NX+j]) * mx[j];
            e[i] = rs(a);
        end
        for (int i = 0; i < NX; i++) begin
            a = 0;
            for (int j = 0; j < NX; j++) a += longint'(cf[OFF_U+i*TU+j]) * mx[j];
            for (int j = 0; j < NU; j++) a += longint'(cf[OFF_U+i*TU+NX+j]) * u[j];
            for (int j = 0; j < NY; j++) a += longint'(cf[OFF_U+i*TU+NX+NU+j]) * e[j];
            nx[i] = rs(a);
        end
        for (int i = 0; i < NX; i++) mx[i] = nx[i];
        for (int i = 0; i < NZ; i++) begin
            a = 0;
            for (int j = 0; j < NX; j++) a += longint'(cf[OFF_O+i*NX+j]) * mx[j];
            it.z[i] = rs(a);
        end
        it.tag = tag;
        @(negedge clk);
        for (int i = 0; i < NY; i++) meas[i*DW +: DW] = DW'(y[i]);
        for (int i = 0; i < NU; i++) act[i*DW +: DW] = DW'(u[i]);
        it.t0 = cyc;
        q.push_back(it);
        start = 1;
        @(negedge clk);
        start = 0;
        check("R2 busy", int'(busy), 1);
        if (disturb) begin
            repeat (100) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
            wr(OFF_O, 12345);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R2 pulse", int'(done), 0);
        @(negedge clk);
        check("R3 idle after step", int'(busy), 0);
    endtask

    task automatic clear_coefs();
        for (int a = 0; a < DEPTH; a++) wr(a, 0);
    endtask

    initial begin
        int y[NY];
        int u[NU];
        for (int i = 0; i < DEPTH; i++) cf[i] = 0;
        for (int i = 0; i < NX; i++) mx[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 est", int'(est != '0), 0);

        // R8, R10: pure B drive, half gains for rounding ties
        clear_coefs();
        for (int i = 0; i < NU; i++) wr(OFF_U + i*TU + NX + i, 16384);
        wr(OFF_O + 0*NX + 0, 8192);
        wr(OFF_O + 1*NX + 1, 8192);
        wr(OFF_O + 2*NX + 2, 16384);
        foreach (y[i]) y[i] = 0;
        u = '{3, -3, 7, 0, 0, 0};
        run_step(y, u, "R8 rounding", 0);
        // next step: A=0 so state still equals B*u
        u = '{-5, 5, -9, 1, 1, 1};
        run_step(y, u, "R8 rounding neg", 0);

        // R5, R6, R7: dense coefficients across chained steps
        for (int a = 0; a < DEPTH; a++) wr(a, rnd_coef(3000));
        for (int s = 0; s < 4; s++) begin
            foreach (y[i]) y[i] = rnd_coef(2000);
            foreach (u[i]) u[i] = rnd_coef(2000);
            run_step(y, u, "R5 R6 R7 dense", 0);
        end

        // R3, R4: stray start and coefficient write during a step
        run_step(y, u, "R3 stray start", 1);
        run_step(y, u, "R4 write ignored", 0);

        // R9: saturation both ways
        clear_coefs();
        for (int i = 0; i < NX; i++) wr(OFF_U + i*TU + NX, (i % 2 == 0) ? 32767 : -32768);
        wr(OFF_O + 0*NX + 0, 32767);
        wr(OFF_O + 1*NX + 1, 32767);
        wr(OFF_O + 2*NX + 0, -32768);
        u = '{30000, 0, 0, 0, 0, 0};
        run_step(y, u, "R9 saturation", 0);
        u = '{-30000, 0, 0, 0, 0, 0};
        run_step(y, u, "R9 saturation neg", 0);

        repeat (5) @(negedge clk);
        check("R3 queue drained", q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule